// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host indirect access to a byte-addressed internal register space that holds 16-bit registers at even addresses. The host writes one 32-bit command word. Bit 31 selects the direction, bits 30:16 carry address bits 15:1, and bits 15:0 carry the write data. The block then runs exactly one access on a simple internal register port. That port has no handshake, and each access lasts a programmed number of cycles. The same 32-bit word is always readable as a status view. Its top bit shows progress, with opposite meaning for writes and reads, and after a read its low half holds the returned data.

A second, legacy entry point takes clause-22 style register numbers (0 to 31) and folds them onto a fixed window of even internal addresses. Writes to register 31 are dropped without any side effect, because that register number selects a page in the legacy scheme and has no counterpart in the flat space. Only one access can be in flight. Commands that arrive during an access are dropped and latched in a sticky overrun indicator. A malformed read command raises a one-cycle error pulse.

Top module: `regwin_bridge`

## Requirements
- R1: After synchronous reset the status word is 0x00000000, `int_req`, `addr_err` and `overrun` are 0, and the block is idle.
- R2: A host command with bit 31 = 1 is a write. Exactly one internal write goes to address {word[30:16],0} with data word[15:0]. While busy the status word is {1, word[30:16], word[15:0]}. On completion bit 31 drops to 0 and the other fields stay.
- R3: A host command with bit 31 = 0 is a read of address {word[30:16],0}. While busy the status word is {0, word[30:16], 16'h0000}. On completion bit 31 becomes 1 and bits 15:0 hold `int_rdata` as sampled in the last access cycle.
- R4: A read command with word[15] = 1 names an odd address and is rejected. `addr_err` is 1 for exactly the one cycle after the accepting edge, `int_req` stays 0 and the status word is unchanged.
- R5: An access keeps `int_req` high for exactly L cycles, where L = `cfg_latency` sampled at acceptance (1 to 15), and a value of 0 counts as 1. `int_addr`, `int_we` and `int_wdata` are stable for the whole access.
- R6: A host or legacy command that arrives while an access is in flight is ignored: the access, the status word and the internal registers are unaffected. It sets `overrun`, which stays 1 until reset.
- R7: A legacy command for register n accesses internal address 0xA400 + 2n, with the same write and read semantics and status layout as R2 and R3. The status address field is therefore 0x5200 + n.
- R8: A legacy write to register 31 is discarded: no internal access, no overrun, and the status word is unchanged.
- R9: When host and legacy commands arrive in the same idle cycle, the host command is served and the legacy command counts as an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_latency | input | 4 | Internal access length in cycles (0 treated as 1) |
| host_valid | input | 1 | Host command strobe |
| host_word | input | 32 | Host command word |
| host_status | output | 32 | Status view: flag, address bits 15:1, data |
| leg_valid | input | 1 | Legacy register-number command strobe |
| leg_write | input | 1 | Legacy command is a write |
| leg_reg | input | 5 | Legacy register number |
| leg_wdata | input | 16 | Legacy write data |
| int_req | output | 1 | Internal access in progress |
| int_we | output | 1 | Internal access is a write |
| int_addr | output | 16 | Internal byte address (always even) |
| int_wdata | output | 16 | Internal write data |
| int_rdata | input | 16 | Internal read data |
| addr_err | output | 1 | One-cycle pulse for a rejected odd-address read |
| overrun | output | 1 | Sticky: a command arrived while busy |

## Verification
Assertions check on every cycle that the flag polarity matches the direction of the access in flight. They also check that completion leaves the flag in the finished state with the sampled read data, that the internal request fields do not move during an access, that an error pulse never coincides with an access, that a busy-time command always raises overrun, and that a page-register write starts nothing. The bench scenarios alone show the end-to-end results. These are the exact access length for each latency setting, the mapping of legacy register numbers to addresses, that read data matches what earlier writes stored, and that dropped commands leave both the status word and the internal register contents untouched.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int HOST_W     = 32;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 16;
    localparam int FLAG_BIT   = HOST_W - 1;
    localparam int ADDR_LSB   = 16;
    localparam int LEG_REG_W  = 5;
    localparam logic [ADDR_W-1:0]    LEG_BASE = 16'hA400;
    localparam logic [LEG_REG_W-1:0] LEG_PAGE = 5'h1F;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xact_t;

    typedef enum logic {ST_IDLE, ST_BUSY} eng_state_e;

    function automatic logic [ADDR_W-1:0] leg_to_addr(input logic [LEG_REG_W-1:0] n);
        return LEG_BASE + {{(ADDR_W-LEG_REG_W-1){1'b0}}, n, 1'b0};
    endfunction

    function automatic logic [HOST_W-1:0] pack_status(input logic flag,
                                                      input logic [ADDR_W-1:0] addr,
                                                      input logic [DATA_W-1:0] data);
        return {flag, addr[ADDR_W-1:1], data};
    endfunction
endpackage

// File: rtl/regwin_host_dec.sv
module regwin_host_dec
    import regwin_pkg::*;
(
    input  logic [HOST_W-1:0] word,
    output xact_t             xact,
    output logic              legal
);
    always_comb begin
        xact.we    = word[FLAG_BIT];
        xact.addr  = {word[FLAG_BIT-1:ADDR_LSB], 1'b0};
        xact.wdata = word[FLAG_BIT] ? word[DATA_W-1:0] : '0;
        // address bit 0 lives in word[15]; only a read gives it that meaning
        legal      = word[FLAG_BIT] | ~word[ADDR_LSB-1];
    end
endmodule

// File: rtl/regwin_leg_map.sv
module regwin_leg_map
    import regwin_pkg::*;
(
    input  logic                 leg_write,
    input  logic [LEG_REG_W-1:0] leg_reg,
    input  logic [DATA_W-1:0]    leg_wdata,
    output xact_t                xact,
    output logic                 drop
);
    always_comb begin
        xact.we    = leg_write;
        xact.addr  = leg_to_addr(leg_reg);
        xact.wdata = leg_write ? leg_wdata : '0;
        drop       = leg_write && (leg_reg == LEG_PAGE);
    end
endmodule

// File: rtl/regwin_engine.sv
module regwin_engine
    import regwin_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LAT_W-1:0]   cfg_lat,
    input  logic               h_valid,
    input  xact_t              h_x,
    input  logic               h_legal,
    input  logic               m_valid,
    input  xact_t              m_x,
    input  logic               m_drop,
    input  logic [DATA_W-1:0]  int_rdata,
    output logic               busy,
    output xact_t              cur,
    output logic [HOST_W-1:0]  status,
    output logic               addr_err,
    output logic               ovr
);
    localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

    eng_state_e       state;
    logic [LAT_W-1:0] cnt;
    logic [LAT_W-1:0] eff_lat;
    logic             idle, h_take, h_bad, m_take, take, ovr_set, last;
    xact_t            pick;

    always_comb begin
        idle    = (state == ST_IDLE);
        h_take  = h_valid && idle && h_legal;
        h_bad   = h_valid && idle && !h_legal;
        m_take  = m_valid && !m_drop && idle && !h_valid;
        take    = h_take || m_take;
        pick    = h_take ? h_x : m_x;
        ovr_set = (h_valid && !idle) || (m_valid && !m_drop && (!idle || h_valid));
        eff_lat = (cfg_lat == '0) ? LAT_ONE : cfg_lat;
        last    = (state == ST_BUSY) && (cnt == LAT_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cur      <= '0;
            status   <= '0;
            addr_err <= 1'b0;
            ovr      <= 1'b0;
        end else begin
            addr_err <= h_bad;
            if (ovr_set) ovr <= 1'b1;
            case (state)
                ST_IDLE: if (take) begin
                    state  <= ST_BUSY;
                    cur    <= pick;
                    cnt    <= eff_lat;
                    status <= pack_status(pick.we, pick.addr, pick.wdata);
                end
                ST_BUSY: if (last) begin
                    state <= ST_IDLE;
                    if (cur.we) status <= pack_status(1'b0, cur.addr, cur.wdata);
                    else        status <= pack_status(1'b1, cur.addr, int_rdata);
                end else begin
                    cnt <= cnt - LAT_ONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state == ST_BUSY);

    // R2
    wr_busy_flag_chk: assert property (@(posedge clk) disable iff (rst)
        busy && cur.we |-> status[FLAG_BIT]);
    // R3
    rd_busy_flag_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !cur.we |-> !status[FLAG_BIT]);
    // R2
    wr_done_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) && cur.we |-> !status[FLAG_BIT]);
    // R3
    rd_done_data_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) && !cur.we |-> status[FLAG_BIT] && status[DATA_W-1:0] == $past(int_rdata));
    // R5
    cur_stable_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(cur));
    // R5
    cnt_live_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt != '0);
    // R6
    ovr_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (h_valid && busy) |=> ovr);
    // R4
    err_no_access_chk: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> !busy);
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LAT_W-1:0]     cfg_latency,
    input  logic                 host_valid,
    input  logic [HOST_W-1:0]    host_word,
    output logic [HOST_W-1:0]    host_status,
    input  logic                 leg_valid,
    input  logic                 leg_write,
    input  logic [LEG_REG_W-1:0] leg_reg,
    input  logic [DATA_W-1:0]    leg_wdata,
    output logic                 int_req,
    output logic                 int_we,
    output logic [ADDR_W-1:0]    int_addr,
    output logic [DATA_W-1:0]    int_wdata,
    input  logic [DATA_W-1:0]    int_rdata,
    output logic                 addr_err,
    output logic                 overrun
);
    xact_t h_x, m_x, cur;
    logic  h_legal, m_drop, busy;

    regwin_host_dec u_hdec (.word(host_word), .xact(h_x), .legal(h_legal));

    regwin_leg_map u_lmap (
        .leg_write(leg_write), .leg_reg(leg_reg), .leg_wdata(leg_wdata),
        .xact(m_x), .drop(m_drop)
    );

    regwin_engine #(.LAT_W(LAT_W)) u_eng (
        .clk(clk), .rst(rst), .cfg_lat(cfg_latency),
        .h_valid(host_valid), .h_x(h_x), .h_legal(h_legal),
        .m_valid(leg_valid), .m_x(m_x), .m_drop(m_drop),
        .int_rdata(int_rdata), .busy(busy), .cur(cur),
        .status(host_status), .addr_err(addr_err), .ovr(overrun)
    );

    assign int_req   = busy;
    assign int_we    = cur.we;
    assign int_addr  = cur.addr;
    assign int_wdata = cur.wdata;

    // R8
    page_drop_chk: assert property (@(posedge clk) disable iff (rst)
        leg_valid && leg_write && leg_reg == LEG_PAGE && !host_valid && !int_req
        |=> !int_req && $stable(host_status));
    // R9
    dual_cmd_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        host_valid && leg_valid && !(leg_write && leg_reg == LEG_PAGE) |=> overrun);
    // R5
    even_addr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_req) |-> !int_addr[0]);
endmodule

// File: tb/regwin_bridge_bench.sv
module regwin_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_latency = '0;
    logic        host_valid = 1'b0;
    logic [31:0] host_word = '0;
    logic [31:0] host_status;
    logic        leg_valid = 1'b0, leg_write = 1'b0;
    logic [4:0]  leg_reg = '0;
    logic [15:0] leg_wdata = '0;
    logic        int_req, int_we, addr_err, overrun;
    logic [15:0] int_addr, int_wdata, int_rdata;

    int checks = 0, errors = 0;
    int req_cycles = 0;
    logic [15:0] seen_addr = '0;
    logic [15:0] mem [256];
    logic [15:0] exp_mem [256];

    always #2 clk = ~clk;

    regwin_bridge u_regwin_bridge (.*);

    function automatic logic [15:0] init_val(input int i);
        return 16'(i * 16'h0101) ^ 16'h5A5A;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else if (int_req && int_we) begin
            mem[int_addr[8:1]] <= int_wdata;
        end
    end
    assign int_rdata = mem[int_addr[8:1]];

    always @(negedge clk) if (int_req) begin
        req_cycles <= req_cycles + 1;
        seen_addr  <= int_addr;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int eff(input logic [3:0] l);
        return (l == 0) ? 1 : int'(l);
    endfunction

    // host command; returns after completion, checking busy-phase flag
    task automatic host_cmd(input logic [31:0] w, input logic [3:0] lat, input bit check_busy);
        @(negedge clk);
        req_cycles  = 0;
        cfg_latency = lat;
        host_valid  = 1'b1;
        host_word   = w;
        @(negedge clk);
        host_valid  = 1'b0;
        if (check_busy) begin
            if (w[31]) chk(host_status == w, "R2 busy status", host_status, w);
            else chk(host_status == {1'b0, w[30:16], 16'h0}, "R3 busy status", host_status, {1'b0, w[30:16], 16'h0});
        end
        repeat (eff(lat)) @(negedge clk);
    endtask

    task automatic leg_cmd(input bit wr, input logic [4:0] n, input logic [15:0] d, input logic [3:0] lat);
        @(negedge clk);
        req_cycles  = 0;
        cfg_latency = lat;
        leg_valid = 1'b1; leg_write = wr; leg_reg = n; leg_wdata = d;
        @(negedge clk);
        leg_valid = 1'b0;
        repeat (eff(lat)) @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    endtask

    bit finished = 1'b0;

    initial begin
        #800000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w, prev, exp_s;
        logic [15:0] a, d;
        logic [3:0]  lat;
        bit          we;
        void'($urandom(32'd20120629));
        do_reset();
        // R1 reset state
        chk(host_status == 0, "R1 status", host_status, 0);
        chk(!int_req && !addr_err && !overrun, "R1 flags",
            {int_req, addr_err, overrun}, 0);

        // R2/R3/R5 random traffic
        for (int k = 0; k < 60; k++) begin
            lat = 4'($urandom % 16);
            we  = 1'($urandom % 2);
            a   = {7'($urandom), 8'($urandom), 1'b0};
            d   = 16'($urandom);
            if (!we) d[15] = 1'b0;
            w = {we, a[15:1], d};
            host_cmd(w, lat, 1'b1);
            chk(req_cycles == eff(lat), "R5 access length", req_cycles, eff(lat));
            chk(seen_addr == a, we ? "R2 address" : "R3 address", seen_addr, a);
            if (we) begin
                exp_mem[a[8:1]] = d;
                exp_s = {1'b0, a[15:1], d};
                chk(host_status == exp_s, "R2 done status", host_status, exp_s);
            end else begin
                exp_s = {1'b1, a[15:1], exp_mem[a[8:1]]};
                chk(host_status == exp_s, "R3 done status", host_status, exp_s);
            end
        end

        // R5 latency corners
        host_cmd({1'b1, 15'h0010, 16'h1111}, 4'd0, 1'b1);
        exp_mem[8'h10] = 16'h1111;
        chk(req_cycles == 1, "R5 lat0", req_cycles, 1);
        host_cmd({1'b0, 15'h0010, 16'h0000}, 4'd15, 1'b1);
        chk(req_cycles == 15, "R5 lat15", req_cycles, 15);
        chk(host_status == {1'b1, 15'h0010, 16'h1111}, "R3 lat15 data", host_status, {1'b1, 15'h0010, 16'h1111});

        // R4 odd-address read
        prev = host_status;
        @(negedge clk);
        req_cycles = 0;
        host_valid = 1'b1; host_word = {1'b0, 15'h1234, 16'h8000};
        @(negedge clk);
        host_valid = 1'b0;
        chk(addr_err == 1'b1, "R4 err pulse", addr_err, 1);
        chk(int_req == 1'b0, "R4 no access", int_req, 0);
        @(negedge clk);
        chk(addr_err == 1'b0, "R4 pulse width", addr_err, 0);
        chk(host_status == prev && req_cycles == 0, "R4 status kept", host_status, prev);

        // R7 legacy write and read
        chk(overrun == 1'b0, "R6 no overrun yet", overrun, 0);
        leg_cmd(1'b1, 5'd5, 16'hBEEF, 4'd3);
        exp_mem[8'h05] = 16'hBEEF;
        chk(seen_addr == 16'hA40A, "R7 legacy address", seen_addr, 16'hA40A);
        chk(host_status == {1'b0, 15'h5205, 16'hBEEF}, "R7 legacy write status", host_status, {1'b0, 15'h5205, 16'hBEEF});
        leg_cmd(1'b0, 5'd5, 16'h0, 4'd2);
        chk(host_status == {1'b1, 15'h5205, 16'hBEEF}, "R7 legacy read", host_status, {1'b1, 15'h5205, 16'hBEEF});
        leg_cmd(1'b0, 5'd31, 16'h0, 4'd1);
        chk(seen_addr == 16'hA43E, "R7 reg31 read address", seen_addr, 16'hA43E);

        // R8 page-register write dropped
        prev = host_status;
        leg_cmd(1'b1, 5'd31, 16'hDEAD, 4'd2);
        chk(req_cycles == 0, "R8 no access", req_cycles, 0);
        chk(host_status == prev, "R8 status kept", host_status, prev);
        chk(overrun == 1'b0, "R8 no overrun", overrun, 0);
        leg_cmd(1'b0, 5'd31, 16'h0, 4'd1);
        chk(host_status[15:0] == exp_mem[8'h1F], "R8 reg31 content", host_status[15:0], exp_mem[8'h1F]);

        // R6 command while busy
        @(negedge clk);
        req_cycles = 0;
        cfg_latency = 4'd6;
        host_valid = 1'b1; host_word = {1'b1, 15'h0021, 16'hAAAA};
        @(negedge clk);
        host_word = {1'b1, 15'h0022, 16'h5555};
        @(negedge clk);
        host_valid = 1'b0;
        repeat (5) @(negedge clk);
        exp_mem[8'h21] = 16'hAAAA;
        chk(seen_addr == 16'h0042, "R6 access kept", seen_addr, 16'h0042);
        chk(host_status == {1'b0, 15'h0021, 16'hAAAA}, "R6 status", host_status, {1'b0, 15'h0021, 16'hAAAA});
        chk(overrun == 1'b1, "R6 overrun set", overrun, 1);
        host_cmd({1'b0, 15'h0022, 16'h0}, 4'd1, 1'b0);
        chk(host_status[15:0] == exp_mem[8'h22], "R6 target untouched", host_status[15:0], exp_mem[8'h22]);
        chk(overrun == 1'b1, "R6 sticky", overrun, 1);
        do_reset();
        chk(overrun == 1'b0 && host_status == 0, "R1 reset clears", {overrun, host_status[30:0]}, 0);

        // R9 simultaneous host and legacy
        @(negedge clk);
        req_cycles = 0;
        cfg_latency = 4'd2;
        host_valid = 1'b1; host_word = {1'b0, 15'h0033, 16'h0};
        leg_valid = 1'b1; leg_write = 1'b0; leg_reg = 5'd7;
        @(negedge clk);
        host_valid = 1'b0; leg_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(seen_addr == 16'h0066, "R9 host wins", seen_addr, 16'h0066);
        chk(req_cycles == 2, "R9 single access", req_cycles, 2);
        chk(host_status == {1'b1, 15'h0033, exp_mem[8'h33]}, "R9 status", host_status, {1'b1, 15'h0033, exp_mem[8'h33]});
        chk(overrun == 1'b1, "R9 overrun", overrun, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule